// File: doc/BRIEF.md
# Flash Program/Erase Unlock Guard

This block stands between a byte-wide register bus and the command inputs of a flash array. It decides when a program or erase command may reach the array. Out of reset it is locked. Software opens it with a fixed sequence of four writes:

1. Write the target page to the page register.
2. Write the first key byte to the control register.
3. Write the second key byte to the control register.
4. Write the page register again with the same value as in step 1.

Any write to those two registers that departs from this order drops the guard back to the locked state, and the sequence then starts again from step 1.

While the guard is open, one command code written to the control register is accepted. The guard then checks two further conditions:

- The 16-bit frequency setting, built from a high and a low byte register, holds a value for a clock between 1 MHz and 8 MHz.
- The sector that holds the page is not protected.

If both hold, the guard gives a one-cycle program or erase pulse together with the page number. A command aimed at a protected sector is refused and raises a sticky violation flag. Every control write made while the guard is open closes it again, whether or not a pulse results.

Top module: `flash_guard_top`

## Requirements
- R1: After reset the guard is locked, no command pulse is issued, and the status register (address 5) reads 0x02: bit 0 is the unlocked flag, bit 1 is the frequency-out-of-range flag and bit 2 is the violation flag.
- R2: Writing the page register (address 0), then writing 0x73 and then 0x8C to the control register (address 1), then writing the page register again with the same value sets status bit 0 after the final write.
- R3: A control write carrying a wrong key byte, or a page write between the two key bytes, returns the guard to the locked state. A later correct sequence then unlocks it again.
- R4: If the final page write carries a value that differs from the stored page, the guard stays locked.
- R5: The frequency value is {high byte at address 2, low byte at address 3}. Status bit 1 is 0 exactly when that value lies in 2000..16000 inclusive. Both bytes read back as written.
- R6: While the guard is unlocked, a control write of 0x6A (program) or 0x95 (erase) raises cmd_prog or cmd_erase for exactly one cycle, starting the cycle after the write, with cmd_page equal to the stored page. The guard is locked afterwards.
- R7: A command while unlocked with the frequency out of range gives no pulse, and the guard relocks.
- R8: The sector of a page is page[6:4], and the sector protect register (address 4) holds one bit per sector. A command to a protected sector gives no pulse and sets status bit 2. That bit stays set until the status register is read.
- R9: Command codes written while the guard is locked produce no pulse.
- R10: A control write with any value other than a command code while unlocked relocks the guard without a pulse.
- R11: The page register and the sector protect register read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; a read of status clears the violation flag |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| cmd_prog | output | 1 | One-cycle program pulse to the array |
| cmd_erase | output | 1 | One-cycle erase pulse to the array |
| cmd_page | output | 7 | Page targeted by the current pulse |

## Verification
The bench goes after the points where the sequence can be broken, and checks each break against what a faulty design would do:

- A wrong second key, or a page write wedged between the keys: a design that only watched for the final page write would unlock anyway.
- A mismatched page confirmation: a design that skipped the compare would accept any page.
- A control write that is not a command: a guard that stayed open afterwards would let a later command through.

The frequency limits are tested one step on each side, at 1999, 2000, 16000 and 16001; an off-by-one or exclusive compare shows up on the status flag. The protect test aims at a sector that is protected and then at one that is not. It reads status twice, so a flag that never sets, never clears, or clears without a read is caught. It also checks that a command pulse never lasts a second cycle.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [2:0] {
        SEQ_LOCKED = 3'd0,
        SEQ_PAGE   = 3'd1,
        SEQ_KEY1   = 3'd2,
        SEQ_KEY2   = 3'd3,
        SEQ_OPEN   = 3'd4
    } seq_state_e;

    localparam logic [2:0] ADDR_PAGE   = 3'd0;
    localparam logic [2:0] ADDR_CTRL   = 3'd1;
    localparam logic [2:0] ADDR_FHI    = 3'd2;
    localparam logic [2:0] ADDR_FLO    = 3'd3;
    localparam logic [2:0] ADDR_PROT   = 3'd4;
    localparam logic [2:0] ADDR_STATUS = 3'd5;

    localparam logic [7:0] KEY_FIRST  = 8'h73;
    localparam logic [7:0] KEY_SECOND = 8'h8C;
    localparam logic [7:0] CODE_PROG  = 8'h6A;
    localparam logic [7:0] CODE_ERASE = 8'h95;

endpackage

// File: rtl/fg_unlock_fsm.sv
module fg_unlock_fsm
    import flash_guard_pkg::*;
#(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_wr,
    input  logic              ctrl_wr,
    input  logic [7:0]        wdata,
    input  logic [PAGE_W-1:0] stored_page,
    output logic              unlocked
);

    typedef struct packed {
        seq_state_e st;
    } fsm_t;

    fsm_t s_d, s_q;
    logic page_match;

    assign page_match = (wdata[PAGE_W-1:0] == stored_page);

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SEQ_LOCKED: begin
                if (page_wr) s_d.st = SEQ_PAGE;
            end
            SEQ_PAGE: begin
                if (ctrl_wr) s_d.st = (wdata == KEY_FIRST) ? SEQ_KEY1 : SEQ_LOCKED;
            end
            SEQ_KEY1: begin
                if (ctrl_wr)      s_d.st = (wdata == KEY_SECOND) ? SEQ_KEY2 : SEQ_LOCKED;
                else if (page_wr) s_d.st = SEQ_LOCKED;
            end
            SEQ_KEY2: begin
                if (page_wr)      s_d.st = page_match ? SEQ_OPEN : SEQ_LOCKED;
                else if (ctrl_wr) s_d.st = SEQ_LOCKED;
            end
            SEQ_OPEN: begin
                if (ctrl_wr || page_wr) s_d.st = SEQ_LOCKED;
            end
            default: s_d.st = SEQ_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.st <= SEQ_LOCKED;
        else        s_q <= s_d;
    end

    assign unlocked = (s_q.st == SEQ_OPEN);

endmodule

// File: rtl/fg_freq_check.sv
module fg_freq_check #(
    parameter int FREQ_W   = 16,
    parameter int FREQ_MIN = 2000,
    parameter int FREQ_MAX = 16000
) (
    input  logic [FREQ_W-1:0] freq,
    output logic              in_range
);

    localparam logic [FREQ_W-1:0] LO = FREQ_W'(FREQ_MIN);
    localparam logic [FREQ_W-1:0] HI = FREQ_W'(FREQ_MAX);

    assign in_range = (freq >= LO) && (freq <= HI);

endmodule

// File: rtl/fg_sector_map.sv
module fg_sector_map #(
    parameter int PAGE_W = 7,
    parameter int SECT_W = 3
) (
    input  logic [PAGE_W-1:0]      page,
    input  logic [(1<<SECT_W)-1:0] prot_mask,
    output logic                   is_protected
);

    localparam int NSECT = 1 << SECT_W;

    logic [SECT_W-1:0] sect;
    logic [NSECT-1:0]  hit;

    assign sect = page[PAGE_W-1 -: SECT_W];

    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        assign hit[s] = (sect == SECT_W'(s)) && prot_mask[s];
    end

    assign is_protected = |hit;

endmodule

// File: rtl/flash_guard_top.sv
module flash_guard_top
    import flash_guard_pkg::*;
#(
    parameter int PAGE_W   = 7,
    parameter int SECT_W   = 3,
    parameter int FREQ_MIN = 2000,
    parameter int FREQ_MAX = 16000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [2:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              cmd_prog,
    output logic              cmd_erase,
    output logic [PAGE_W-1:0] cmd_page
);

    localparam int NSECT  = 1 << SECT_W;
    localparam int FREQ_W = 16;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [7:0]        fhi;
        logic [7:0]        flo;
        logic [NSECT-1:0]  prot;
        logic              viol;
        logic              prog;
        logic              erase;
    } regs_t;

    regs_t r_d, r_q;

    logic              page_wr, ctrl_wr, status_rd;
    logic              unlocked, freq_ok, page_prot;
    logic              is_cmd, cmd_ok;
    logic              sticky_viol;
    logic [FREQ_W-1:0] freq_val;
    logic [7:0]        page_rb, prot_rb, status_rb;

    assign page_wr   = bus_we && (bus_addr == ADDR_PAGE);
    assign ctrl_wr   = bus_we && (bus_addr == ADDR_CTRL);
    assign status_rd = bus_re && (bus_addr == ADDR_STATUS);
    assign freq_val  = {r_q.fhi, r_q.flo};

    fg_unlock_fsm #(.PAGE_W(PAGE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .page_wr     (page_wr),
        .ctrl_wr     (ctrl_wr),
        .wdata       (bus_wdata),
        .stored_page (r_q.page),
        .unlocked    (unlocked)
    );

    fg_freq_check #(
        .FREQ_W   (FREQ_W),
        .FREQ_MIN (FREQ_MIN),
        .FREQ_MAX (FREQ_MAX)
    ) u_freq (
        .freq     (freq_val),
        .in_range (freq_ok)
    );

    fg_sector_map #(.PAGE_W(PAGE_W), .SECT_W(SECT_W)) u_sect (
        .page         (r_q.page),
        .prot_mask    (r_q.prot),
        .is_protected (page_prot)
    );

    assign is_cmd = (bus_wdata == CODE_PROG) || (bus_wdata == CODE_ERASE);
    assign cmd_ok = ctrl_wr && unlocked && is_cmd && freq_ok && !page_prot;

    always_comb begin
        r_d       = r_q;
        r_d.prog  = 1'b0;
        r_d.erase = 1'b0;

        if (page_wr) r_d.page = bus_wdata[PAGE_W-1:0];
        if (bus_we && (bus_addr == ADDR_FHI))  r_d.fhi  = bus_wdata;
        if (bus_we && (bus_addr == ADDR_FLO))  r_d.flo  = bus_wdata;
        if (bus_we && (bus_addr == ADDR_PROT)) r_d.prot = bus_wdata[NSECT-1:0];

        if (status_rd) r_d.viol = 1'b0;

        if (cmd_ok) begin
            r_d.prog  = (bus_wdata == CODE_PROG);
            r_d.erase = (bus_wdata == CODE_ERASE);
        end

        if (ctrl_wr && unlocked && is_cmd && freq_ok && page_prot)
            r_d.viol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd_prog    = r_q.prog;
    assign cmd_erase   = r_q.erase;
    assign cmd_page    = r_q.page;
    assign sticky_viol = r_q.viol;

    always_comb begin
        page_rb                = '0;
        page_rb[PAGE_W-1:0]    = r_q.page;
        prot_rb                = '0;
        prot_rb[NSECT-1:0]     = r_q.prot;
        status_rb              = '0;
        status_rb[0]           = unlocked;
        status_rb[1]           = !freq_ok;
        status_rb[2]           = r_q.viol;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_PAGE:   bus_rdata = page_rb;
            ADDR_FHI:    bus_rdata = r_q.fhi;
            ADDR_FLO:    bus_rdata = r_q.flo;
            ADDR_PROT:   bus_rdata = prot_rb;
            ADDR_STATUS: bus_rdata = status_rb;
            default:     bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk
    import flash_guard_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic       bus_re,
    input logic [2:0] bus_addr,
    input logic       cmd_prog,
    input logic       cmd_erase,
    input logic       unlocked,
    input logic       freq_ok,
    input logic       page_prot,
    input logic       viol
);

    // R6
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_prog, cmd_erase}));

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_prog || cmd_erase) |=> !(cmd_prog || cmd_erase));

    // R9
    pulse_needs_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_prog || cmd_erase) |-> $past(bus_we && (bus_addr == ADDR_CTRL)));

    // R6
    relock_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_prog || cmd_erase) |-> !unlocked);

    // R7
    pulse_freq_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_prog || cmd_erase) |-> $past(freq_ok && !page_prot));

    // R2
    unlock_by_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_we && (bus_addr == ADDR_PAGE)));

    // R8
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && !(bus_re && (bus_addr == ADDR_STATUS))) |=> viol);

endmodule

bind flash_guard_top flash_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .cmd_prog  (cmd_prog),
    .cmd_erase (cmd_erase),
    .unlocked  (unlocked),
    .freq_ok   (freq_ok),
    .page_prot (page_prot),
    .viol      (sticky_viol)
);

// File: tb/flash_guard_top_test.sv
module flash_guard_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cmd_prog, cmd_erase;
    logic [6:0] cmd_page;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    flash_guard_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cmd_prog  (cmd_prog),
        .cmd_erase (cmd_erase),
        .cmd_page  (cmd_page)
    );

    always #4 clk = ~clk;

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic unlock(logic [7:0] pg);
        wr(3'd0, pg); wr(3'd1, 8'h73); wr(3'd1, 8'h8C); wr(3'd0, pg);
    endtask

    // issue a command; check pulse in next cycle and drop after
    task automatic cmd_and_check(string req, logic [7:0] code, int exp_p, int exp_e, int exp_pg);
        wr(3'd1, code);
        check(req, cmd_prog, exp_p);
        check(req, cmd_erase, exp_e);
        if (exp_p || exp_e) check(req, cmd_page, exp_pg);
        @(negedge clk);
        check(req, cmd_prog | cmd_erase, 0);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        check("R1", cmd_prog | cmd_erase, 0);
        rd(3'd5, s);
        check("R1", s, 8'h02);
    endtask

    task automatic t_freq();
        logic [7:0] s;
        wr(3'd2, 8'h07); wr(3'd3, 8'hCF);
        rd(3'd5, s); check("R5 1999", s[1], 1);
        wr(3'd3, 8'hD0);
        rd(3'd5, s); check("R5 2000", s[1], 0);
        wr(3'd2, 8'h3E); wr(3'd3, 8'h80);
        rd(3'd5, s); check("R5 16000", s[1], 0);
        wr(3'd3, 8'h81);
        rd(3'd5, s); check("R5 16001", s[1], 1);
        rd(3'd2, s); check("R5 hi", s, 8'h3E);
        rd(3'd3, s); check("R5 lo", s, 8'h81);
        wr(3'd2, 8'h0F); wr(3'd3, 8'hA0);
        rd(3'd5, s); check("R5 4000", s[1], 0);
    endtask

    task automatic t_unlock_cmds();
        logic [7:0] s;
        unlock(8'h12);
        rd(3'd5, s); check("R2", s[0], 1);
        cmd_and_check("R6 prog", 8'h6A, 1, 0, 8'h12);
        rd(3'd5, s); check("R6 relock", s[0], 0);
        unlock(8'h33);
        cmd_and_check("R6 erase", 8'h95, 0, 1, 8'h33);
        cmd_and_check("R6 second cmd", 8'h95, 0, 0, 0);
    endtask

    task automatic t_locked_cmd();
        cmd_and_check("R9 prog", 8'h6A, 0, 0, 0);
        cmd_and_check("R9 erase", 8'h95, 0, 0, 0);
    endtask

    task automatic t_bad_key();
        logic [7:0] s;
        wr(3'd0, 8'h10); wr(3'd1, 8'h73); wr(3'd1, 8'h8D); wr(3'd0, 8'h10);
        rd(3'd5, s); check("R3 wrong key", s[0], 0);
        wr(3'd0, 8'h10); wr(3'd1, 8'h8C); wr(3'd1, 8'h73); wr(3'd0, 8'h10);
        rd(3'd5, s); check("R3 key order", s[0], 0);
        wr(3'd0, 8'h10); wr(3'd1, 8'h73); wr(3'd0, 8'h10); wr(3'd1, 8'h8C); wr(3'd0, 8'h10);
        rd(3'd5, s); check("R3 page between keys", s[0], 0);
        unlock(8'h10);
        rd(3'd5, s); check("R3 restart", s[0], 1);
        cmd_and_check("R3 restart cmd", 8'h6A, 1, 0, 8'h10);
    endtask

    task automatic t_page_mismatch();
        logic [7:0] s;
        wr(3'd0, 8'h05); wr(3'd1, 8'h73); wr(3'd1, 8'h8C); wr(3'd0, 8'h06);
        rd(3'd5, s); check("R4", s[0], 0);
        wr(3'd0, 8'h06);
        rd(3'd5, s); check("R4 no retry", s[0], 0);
        cmd_and_check("R4 cmd", 8'h6A, 0, 0, 0);
    endtask

    task automatic t_freq_block();
        logic [7:0] s;
        wr(3'd2, 8'h3E); wr(3'd3, 8'h81);
        unlock(8'h20);
        cmd_and_check("R7", 8'h6A, 0, 0, 0);
        rd(3'd5, s); check("R7 relock", s[0], 0);
        check("R7 no viol", s[2], 0);
        wr(3'd2, 8'h0F); wr(3'd3, 8'hA0);
    endtask

    task automatic t_protect();
        logic [7:0] s;
        wr(3'd4, 8'h04);
        rd(3'd4, s); check("R11 prot rb", s, 8'h04);
        unlock(8'h25);
        rd(3'd0, s); check("R11 page rb", s, 8'h25);
        cmd_and_check("R8 blocked", 8'h95, 0, 0, 0);
        wr(3'd2, 8'h0F);
        rd(3'd5, s); check("R8 flag set", s[2], 1);
        rd(3'd5, s); check("R8 flag cleared", s[2], 0);
        unlock(8'h15);
        cmd_and_check("R8 other sector", 8'h95, 0, 1, 8'h15);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_other_ctrl();
        logic [7:0] s;
        unlock(8'h41);
        cmd_and_check("R10 non-cmd", 8'h00, 0, 0, 0);
        rd(3'd5, s); check("R10 relock", s[0], 0);
        cmd_and_check("R10 later cmd", 8'h6A, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_freq();
        t_unlock_cmds();
        t_locked_cmd();
        t_bad_key();
        t_page_mismatch();
        t_freq_block();
        t_protect();
        t_other_ctrl();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule